// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port Controller

This block holds the register state of a sixteen-pin general-purpose I/O port and drives each pin's output value and output enable. Software reaches it through a single-cycle write port with a byte offset and an access-width flag. A pin's function select, its output data, its input enable and a 32-bit pin-mux word each have their own register. The data and direction registers can also be changed atomically through dedicated set and clear offsets, so no read-modify-write is needed.

The access width is checked before the offset is decoded. The mux word takes only 32-bit writes and every other offset takes only 16-bit writes. A write of the wrong width, or a write to an offset with no register, raises a one-cycle error flag and changes nothing. Pin output values are latched when data or direction is written through certain offsets, and only for pins that are not input-enabled. Each pin's output enable follows its direction bit, masked by its input enable.

The write port is plain control: there is no back-pressure, and a write is taken on every cycle in which `wr_en` is high.

Top module: `gpio_port_ctl`

## Requirements
- R1: After reset, every register, `pin_out`, `pin_oe`, `func_en`, `pin_in_en`, `mux_sel` and both error flags are zero.
- R2: A 16-bit write (`wr_wide`=0) to offset 0x00 loads `func_en`, to offset 0x04 loads the data register, and to offset 0x18 loads `pin_in_en`, each from `wr_data[15:0]`.
- R3: A 16-bit write to offset 0x0C ORs `wr_data[15:0]` into the data register.
- R4: A 16-bit write to offset 0x08 clears each data bit whose `wr_data` bit is 1 and leaves the others unchanged.
- R5: A 16-bit write to offset 0x14 ORs `wr_data[15:0]` into the direction register, and one to offset 0x10 clears the direction bits written as 1.
- R6: `pin_oe` equals the direction register ANDed with the inverse of `pin_in_en`, and is visible in the cycle after the write that changes either of them.
- R7: After a write to offset 0x04, 0x08, 0x0C or 0x14, each pin whose `pin_in_en` bit is 0 shows its new data bit on `pin_out`, and each pin whose bit is 1 keeps its previous `pin_out` value. Writes to any other offset leave `pin_out` unchanged.
- R8: A 32-bit write (`wr_wide`=1) to offset 0x1C loads `mux_sel` from all 32 bits of `wr_data`.
- R9: A write to offset 0x1C with `wr_wide`=0, or to any other offset with `wr_wide`=1, whether the offset is mapped or not, sets `err_width` for exactly one cycle, leaves `err_addr` low and changes no register and no output.
- R10: A 16-bit write to an offset that has no register (any offset other than the eight above, including misaligned ones) sets `err_addr` for exactly one cycle and changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W (6) | Byte offset of the write |
| wr_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| wr_data | input | MUX_W (32) | Write data; 16-bit accesses use the low half |
| err_width | output | 1 | One-cycle pulse: access width not allowed at this offset |
| err_addr | output | 1 | One-cycle pulse: offset has no register |
| pin_out | output | PIN_W (16) | Latched per-pin output values |
| pin_oe | output | PIN_W (16) | Per-pin output enables |
| func_en | output | PIN_W (16) | Per-pin function-select register |
| pin_in_en | output | PIN_W (16) | Per-pin input-enable register |
| mux_sel | output | MUX_W (32) | Pin-mux word |

## Verification
The assertions take for granted that `wr_en`, `wr_addr` and `wr_wide` are never unknown while reset is released, and that `wr_addr` and `wr_data` are held for the whole cycle in which `wr_en` is high. The stimulus drives every input at the falling edge from a single task and keeps `wr_en` low in the cycle after each write, so every error pulse and every quiet-cycle hold property is seen in isolation. The bench sweeps all 64 offsets at both access widths over several data patterns and compares every output against a model of the registers after each write.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  // Byte offsets of the register map.
  localparam int unsigned OFS_FER   = 'h00;
  localparam int unsigned OFS_DATA  = 'h04;
  localparam int unsigned OFS_DCLR  = 'h08;
  localparam int unsigned OFS_DSET  = 'h0C;
  localparam int unsigned OFS_RCLR  = 'h10;
  localparam int unsigned OFS_RSET  = 'h14;
  localparam int unsigned OFS_INEN  = 'h18;
  localparam int unsigned OFS_MUX   = 'h1C;

  // One-hot write selects produced by the decoder.
  typedef struct packed {
    logic fer;
    logic data;
    logic dclr;
    logic dset;
    logic rclr;
    logic rset;
    logic inen;
    logic mux;
  } gpio_sel_t;

endpackage

// File: rtl/gpio_wr_decode.sv
module gpio_wr_decode
  import gpio_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_wide,
  output gpio_sel_t         sel,
  output logic              bad_width,
  output logic              bad_addr
);

  logic to_mux;
  logic width_ok;

  assign to_mux   = (wr_addr == ADDR_W'(OFS_MUX));
  // Width rule comes first: mux needs 32-bit, everything else 16-bit.
  assign width_ok = to_mux ? wr_wide : !wr_wide;

  always_comb begin
    sel       = '0;
    bad_width = 1'b0;
    bad_addr  = 1'b0;
    if (wr_en) begin
      if (!width_ok) begin
        bad_width = 1'b1;
      end else begin
        case (wr_addr)
          ADDR_W'(OFS_FER):  sel.fer  = 1'b1;
          ADDR_W'(OFS_DATA): sel.data = 1'b1;
          ADDR_W'(OFS_DCLR): sel.dclr = 1'b1;
          ADDR_W'(OFS_DSET): sel.dset = 1'b1;
          ADDR_W'(OFS_RCLR): sel.rclr = 1'b1;
          ADDR_W'(OFS_RSET): sel.rset = 1'b1;
          ADDR_W'(OFS_INEN): sel.inen = 1'b1;
          ADDR_W'(OFS_MUX):  sel.mux  = 1'b1;
          default:           bad_addr = 1'b1;
        endcase
      end
    end
  end

endmodule

// File: rtl/gpio_bitreg.sv
module gpio_bitreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic         set,
  input  logic         clr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q,
  output logic [W-1:0] q_nxt
);

  always_comb begin
    q_nxt = q;
    if (ld)  q_nxt = wdata;
    if (set) q_nxt = q_nxt | wdata;
    if (clr) q_nxt = q_nxt & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl
  import gpio_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int PIN_W  = 16,
  parameter int MUX_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_wide,
  input  logic [MUX_W-1:0]  wr_data,
  output logic              err_width,
  output logic              err_addr,
  output logic [PIN_W-1:0]  pin_out,
  output logic [PIN_W-1:0]  pin_oe,
  output logic [PIN_W-1:0]  func_en,
  output logic [PIN_W-1:0]  pin_in_en,
  output logic [MUX_W-1:0]  mux_sel
);

  gpio_sel_t        sel;
  logic             bad_width_c;
  logic             bad_addr_c;
  logic [PIN_W-1:0] half;
  logic [PIN_W-1:0] data_q, data_nxt;
  logic [PIN_W-1:0] dir_q, dir_nxt;
  logic [PIN_W-1:0] fer_nxt, inen_nxt;
  logic [MUX_W-1:0] mux_nxt;
  logic             pin_upd;
  logic [PIN_W-1:0] pin_q;
  logic             err_w_q, err_a_q;

  assign half = wr_data[PIN_W-1:0];

  gpio_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_wide   (wr_wide),
    .sel       (sel),
    .bad_width (bad_width_c),
    .bad_addr  (bad_addr_c)
  );

  gpio_bitreg #(.W(PIN_W)) u_fer (
    .clk(clk), .rst_n(rst_n), .ld(sel.fer), .set(1'b0), .clr(1'b0),
    .wdata(half), .q(func_en), .q_nxt(fer_nxt)
  );

  gpio_bitreg #(.W(PIN_W)) u_data (
    .clk(clk), .rst_n(rst_n), .ld(sel.data), .set(sel.dset), .clr(sel.dclr),
    .wdata(half), .q(data_q), .q_nxt(data_nxt)
  );

  gpio_bitreg #(.W(PIN_W)) u_dir (
    .clk(clk), .rst_n(rst_n), .ld(1'b0), .set(sel.rset), .clr(sel.rclr),
    .wdata(half), .q(dir_q), .q_nxt(dir_nxt)
  );

  gpio_bitreg #(.W(PIN_W)) u_inen (
    .clk(clk), .rst_n(rst_n), .ld(sel.inen), .set(1'b0), .clr(1'b0),
    .wdata(half), .q(pin_in_en), .q_nxt(inen_nxt)
  );

  gpio_bitreg #(.W(MUX_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .ld(sel.mux), .set(1'b0), .clr(1'b0),
    .wdata(wr_data), .q(mux_sel), .q_nxt(mux_nxt)
  );

  // Pin values refresh only on writes that touch data or set direction.
  assign pin_upd = sel.data | sel.dset | sel.dclr | sel.rset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q   <= '0;
      err_w_q <= 1'b0;
      err_a_q <= 1'b0;
    end else begin
      err_w_q <= bad_width_c;
      err_a_q <= bad_addr_c;
      if (pin_upd) pin_q <= (pin_q & pin_in_en) | (data_nxt & ~pin_in_en);
    end
  end

  assign pin_out   = pin_q;
  assign pin_oe    = dir_q & ~pin_in_en;
  assign err_width = err_w_q;
  assign err_addr  = err_a_q;

  // Error kinds never overlap.
  assert_err_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_width && err_addr));

  // A width error leaves every register and output as it was.
  assert_width_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_width |-> ($stable(mux_sel) && $stable(func_en) && $stable(pin_in_en)
                   && $stable(pin_oe) && $stable(pin_out)));

  // An unmapped offset leaves every register and output as it was.
  assert_addr_err_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_addr |-> ($stable(mux_sel) && $stable(func_en) && $stable(pin_in_en)
                  && $stable(pin_oe) && $stable(pin_out)));

  // No write, no change of pin values.
  assert_pin_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pin_out));

  // Input-enabled pins never change their presented value.
  assert_inen_pin_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((pin_out ^ $past(pin_out)) & $past(pin_in_en)) == '0));

  // Errors are single-cycle pulses when the write port goes idle.
  assert_err_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (!err_width && !err_addr));

endmodule

// File: tb/tb_gpio_port_ctl.sv
module tb_gpio_port_ctl;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;
  localparam int PIN_W  = 16;
  localparam int MUX_W  = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic              wr_wide = 1'b0;
  logic [MUX_W-1:0]  wr_data = '0;
  logic              err_width, err_addr;
  logic [PIN_W-1:0]  pin_out, pin_oe, func_en, pin_in_en;
  logic [MUX_W-1:0]  mux_sel;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Bench model
  logic [PIN_W-1:0] m_fer, m_data, m_dir, m_inen, m_out;
  logic [MUX_W-1:0] m_mux;
  logic [31:0] lcg = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_ctl #(.ADDR_W(ADDR_W), .PIN_W(PIN_W), .MUX_W(MUX_W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_wide(wr_wide), .wr_data(wr_data), .err_width(err_width),
    .err_addr(err_addr), .pin_out(pin_out), .pin_oe(pin_oe),
    .func_en(func_en), .pin_in_en(pin_in_en), .mux_sel(mux_sel)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string ctx);
    chk({"R2 func_en ", ctx}, 32'(func_en), 32'(m_fer));
    chk({"R2 pin_in_en ", ctx}, 32'(pin_in_en), 32'(m_inen));
    chk({"R8 mux_sel ", ctx}, mux_sel, m_mux);
    chk({"R6 pin_oe ", ctx}, 32'(pin_oe), 32'(m_dir & ~m_inen));
    chk({"R7 pin_out ", ctx}, 32'(pin_out), 32'(m_out));
  endtask

  task automatic wr(input int addr, input bit wide, input logic [31:0] d);
    logic [PIN_W-1:0] h;
    bit exp_w, exp_a, upd;
    h = d[PIN_W-1:0];
    exp_w = (addr == 'h1C) ? !wide : wide;
    exp_a = 1'b0;
    upd = 1'b0;
    if (!exp_w) begin
      case (addr)
        'h00: m_fer = h;
        'h04: begin m_data = h; upd = 1; end
        'h08: begin m_data = m_data & ~h; upd = 1; end
        'h0C: begin m_data = m_data | h; upd = 1; end
        'h10: m_dir = m_dir & ~h;
        'h14: begin m_dir = m_dir | h; upd = 1; end
        'h18: m_inen = h;
        'h1C: m_mux = d;
        default: exp_a = 1'b1;
      endcase
    end
    if (upd) m_out = (m_out & m_inen) | (m_data & ~m_inen);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ADDR_W'(addr); wr_wide = wide; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R9 err_width pulse", 32'(err_width), 32'(exp_w));
    chk("R10 err_addr pulse", 32'(err_addr), 32'(exp_a));
    chk_state($sformatf("after write ofs=%0h wide=%0d", addr, wide));
    @(negedge clk);
    chk("R9 R10 error flags drop", {30'd0, err_width, err_addr}, 32'd0);
  endtask

  function automatic logic [31:0] next_rand();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg;
  endfunction

  initial begin
    m_fer = '0; m_data = '0; m_dir = '0; m_inen = '0; m_out = '0; m_mux = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 err flags", {30'd0, err_width, err_addr}, 32'd0);
    chk_state("R1 reset");

    // Directed: set/clear semantics
    wr('h14, 0, 32'h0000_00FF);            // R5 dir set
    wr('h04, 0, 32'h0000_A5A5);            // R2 data load
    wr('h0C, 0, 32'h0000_0F00);            // R3 data set
    wr('h08, 0, 32'h0000_0005);            // R4 data clear
    wr('h18, 0, 32'h0000_000F);            // R6 inen masks oe
    wr('h04, 0, 32'h0000_FFFF);            // R7 inen pins hold
    wr('h10, 0, 32'h0000_0003);            // R5 dir clear, no pin refresh
    wr('h1C, 1, 32'hDEAD_BEEF);            // R8 mux
    wr('h1C, 0, 32'h1111_2222);            // R9 mux narrow
    wr('h04, 1, 32'h0000_0000);            // R9 wide to 16-bit reg
    wr('h22, 0, 32'h0000_FFFF);            // R10 unmapped
    wr('h3E, 1, 32'h0000_FFFF);            // R9 wide to unmapped
    wr('h06, 0, 32'h0000_FFFF);            // R10 misaligned

    // Sweep all offsets, both widths, three data patterns
    for (int p = 0; p < 3; p++) begin
      for (int a = 0; a < (1 << ADDR_W); a++) begin
        for (int w = 0; w < 2; w++) begin
          logic [31:0] d;
          if (p == 0)      d = next_rand();
          else if (p == 1) d = 32'hFFFF_FFFF ^ {16'd0, 16'(a)};
          else             d = (a[0] ? 32'hAAAA_5555 : 32'h5555_AAAA) ^ next_rand();
          wr(a, w[0], d);
        end
      end
    end

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule